// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is an SPI master for 8-bit characters. A host reaches it through a small register port with separate write and read strobes. The host sets the clock polarity, the clock phase and the bit order, and it sets a divider value that fixes the serial clock rate. It then writes bytes into a holding register. The engine moves each byte from the holding register into its shifter. While the shifter is busy, one more byte can wait in the holding register, so a stream of bytes goes out with no pause in the serial clock.

The engine drives an active-low chip select for the whole stream. Chip select falls half a clock period before the first edge and rises half a period after the last edge, once nothing more is waiting. The byte received on the input line goes into a receive buffer that the host reads through the same data address.

Three flags report the state of the block: holding register empty, stream complete and byte received. Each flag has its own interrupt enable, and the enabled flags are combined onto one interrupt line.

Top module: `spim_master`

## Requirements
- R1: While chip select is high, SCK rests at the configured polarity bit (CFG bit 0). After a polarity change made while idle, SCK takes the new level within two clock cycles.
- R2: With phase bit CFG bit 1 = 0, the first bit is on MOSI before the first SCK edge. Both ends sample on leading edges and change data on trailing edges. With the phase bit = 1, data changes on leading edges and is sampled on trailing edges.
- R3: With CFG bit 2 = 0, bit 7 is sent and received first. With CFG bit 2 = 1, bit 0 goes first.
- R4: Every SCK half period lasts BAUD+1 system clocks. BAUD is the 8-bit register at address 1.
- R5: Chip select falls BAUD+1 clocks before the first SCK edge. It rises BAUD+1 clocks after the last edge when no byte is waiting. A single-byte frame has exactly 16 SCK edges.
- R6: A byte written while a transfer is in progress follows the current byte with no extra SCK delay. Chip select stays low across the boundary.
- R7: Flag bit 0 (empty) reads 1 whenever the holding register can take a byte. A DATA write made while this bit is 0 is discarded.
- R8: Flag bit 1 (complete) sets when a byte finishes and none is waiting. Writing 1 to flag-register bit 1 clears it, and an accepted DATA write also clears it.
- R9: Flag bit 2 (received) sets when a byte finishes. Reading DATA (address 2) returns that byte and clears the flag.
- R10: irq_o is 1 when any flag is 1 and its enable is set. The enables are bits 6:4 of address 3, in the same order as the flags. The line follows the flag state one clock later.
- R11: The register map is: address 0 holds the configuration, 1 holds BAUD, 2 is DATA and 3 holds the flags and enables. After reset every register reads 0 except the empty flag, which reads 1. At reset chip select is high and SCK, MOSI and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the clock after the read strobe |
| irq_o | output | 1 | Combined interrupt |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |
| spi_cs_n_o | output | 1 | Active-low chip select |

## Verification
A wrong bit index or a wrong bit-order decision shows up as a wrong byte at the bench's slave model, and as a wrong DATA readback as soon as the frame ends. A divider that loses count shows up as an SCK half period of the wrong length at the very next edge. Wrong edge-parity state shows up in two ways: SCK no longer returns to its idle level when chip select rises, or the total edge count stops being 16 per byte. Flag state errors can be read back at address 3 right after the frame, and they show on irq_o one clock after the flag changes.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

  localparam logic [1:0] SPIM_ADDR_CFG   = 2'd0;
  localparam logic [1:0] SPIM_ADDR_BAUD  = 2'd1;
  localparam logic [1:0] SPIM_ADDR_DATA  = 2'd2;
  localparam logic [1:0] SPIM_ADDR_FLAGS = 2'd3;

  localparam int FLAG_EMPTY = 0;
  localparam int FLAG_DONE  = 1;
  localparam int FLAG_RECV  = 2;
  localparam int IE_LSB     = 4;

  typedef struct packed {
    logic lsb_first;
    logic cpha;
    logic cpol;
  } spim_cfg_t;

  typedef enum logic [1:0] {
    SPIM_IDLE,
    SPIM_XFER,
    SPIM_TAIL
  } spim_state_t;

endpackage

// File: rtl/spim_baud.sv
`timescale 1ns/1ps
module spim_baud #(
  parameter int BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              tick_o
);

  logic [BAUD_W-1:0] cnt_q;

  assign tick_o = run_i && !restart_i && (cnt_q == baud_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q == baud_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + BAUD_W'(1);
    end
  end

endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  spim_cfg_t         cfg_i,
  input  logic              tick_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              miso_i,
  output logic              take_o,
  output logic              done_o,
  output logic              frame_end_o,
  output logic              run_o,
  output logic              restart_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_n_o
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  spim_state_t       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next, rx_buf_q;
  logic              sck_q, mosi_q, cs_n_q;
  logic              lead_w, last_w, edge_w, done_w, start_w, sample_w;

  function automatic logic [IDX_W-1:0] pos(input logic lsb, input logic [IDX_W-1:0] i);
    return lsb ? i : LAST - i;
  endfunction

  assign lead_w   = (sck_q == cfg_i.cpol);
  assign last_w   = (idx_q == LAST);
  assign edge_w   = (state_q == SPIM_XFER) && tick_i;
  assign done_w   = edge_w && !lead_w && last_w;
  assign start_w  = hold_full_i && (state_q == SPIM_IDLE || state_q == SPIM_TAIL);
  assign sample_w = edge_w && (lead_w ^ cfg_i.cpha);

  always_comb begin
    rx_next = rx_q;
    if (sample_w) rx_next[pos(cfg_i.lsb_first, idx_q)] = miso_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= SPIM_IDLE;
      idx_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_buf_q <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      cs_n_q   <= 1'b1;
    end else begin
      rx_q <= rx_next;
      unique case (state_q)
        SPIM_IDLE, SPIM_TAIL: begin
          if (state_q == SPIM_IDLE) sck_q <= cfg_i.cpol;
          if (start_w) begin
            tx_q    <= hold_data_i;
            idx_q   <= '0;
            cs_n_q  <= 1'b0;
            state_q <= SPIM_XFER;
            if (!cfg_i.cpha) mosi_q <= hold_data_i[pos(cfg_i.lsb_first, '0)];
          end else if (state_q == SPIM_TAIL && tick_i) begin
            cs_n_q  <= 1'b1;
            state_q <= SPIM_IDLE;
          end
        end
        SPIM_XFER: begin
          if (tick_i) begin
            sck_q <= ~sck_q;
            if (lead_w && cfg_i.cpha) mosi_q <= tx_q[pos(cfg_i.lsb_first, idx_q)];
            if (!lead_w) begin
              if (last_w) begin
                rx_buf_q <= rx_next;
                if (hold_full_i) begin
                  tx_q  <= hold_data_i;
                  idx_q <= '0;
                  if (!cfg_i.cpha) mosi_q <= hold_data_i[pos(cfg_i.lsb_first, '0)];
                end else begin
                  state_q <= SPIM_TAIL;
                end
              end else begin
                idx_q <= idx_q + IDX_W'(1);
                if (!cfg_i.cpha) mosi_q <= tx_q[pos(cfg_i.lsb_first, idx_q + IDX_W'(1))];
              end
            end
          end
        end
        default: state_q <= SPIM_IDLE;
      endcase
    end
  end

  assign take_o      = start_w || (done_w && hold_full_i);
  assign done_o      = done_w;
  assign frame_end_o = done_w && !hold_full_i;
  assign run_o       = (state_q != SPIM_IDLE);
  assign restart_o   = start_w;
  assign rx_byte_o   = rx_buf_q;
  assign sck_o       = sck_q;
  assign mosi_o      = mosi_q;
  assign cs_n_o      = cs_n_q;

  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_n_q && $past(cs_n_q) && $stable(cfg_i.cpol) && $past(state_q == SPIM_IDLE)) |-> (sck_q == cfg_i.cpol));

  // R4
  sck_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != SPIM_IDLE && !tick_i) |=> $stable(sck_q));

  // R5
  cs_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(cs_n_q) |-> $past(!hold_full_i));

endmodule

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output spim_cfg_t         cfg_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              hold_full_o,
  output logic [DATA_W-1:0] hold_data_o,
  input  logic              take_i,
  input  logic              done_i,
  input  logic              frame_end_i,
  input  logic [DATA_W-1:0] rx_byte_i
);

  spim_cfg_t         cfg_q;
  logic [BAUD_W-1:0] baud_q;
  logic [DATA_W-1:0] hold_data_q, rdata_q;
  logic              hold_full_q, done_flag_q, recv_flag_q, irq_q;
  logic [2:0]        ie_q, flags_w;
  logic              data_wr_w, data_acc_w, data_rd_w, flag_wr_w;

  assign data_wr_w  = wr_i && (addr_i == SPIM_ADDR_DATA);
  assign data_acc_w = data_wr_w && !hold_full_q;
  assign data_rd_w  = rd_i && (addr_i == SPIM_ADDR_DATA);
  assign flag_wr_w  = wr_i && (addr_i == SPIM_ADDR_FLAGS);

  always_comb begin
    flags_w = '0;
    flags_w[FLAG_EMPTY] = !hold_full_q;
    flags_w[FLAG_DONE]  = done_flag_q;
    flags_w[FLAG_RECV]  = recv_flag_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q       <= '0;
      baud_q      <= '0;
      hold_data_q <= '0;
      hold_full_q <= 1'b0;
      done_flag_q <= 1'b0;
      recv_flag_q <= 1'b0;
      ie_q        <= '0;
      rdata_q     <= '0;
      irq_q       <= 1'b0;
    end else begin
      if (wr_i && addr_i == SPIM_ADDR_CFG)  cfg_q  <= spim_cfg_t'(wdata_i[2:0]);
      if (wr_i && addr_i == SPIM_ADDR_BAUD) baud_q <= wdata_i[BAUD_W-1:0];
      if (flag_wr_w) ie_q <= wdata_i[IE_LSB+2:IE_LSB];

      if (data_acc_w) begin
        hold_data_q <= wdata_i;
        hold_full_q <= 1'b1;
      end else if (take_i) begin
        hold_full_q <= 1'b0;
      end

      if (data_acc_w || (flag_wr_w && wdata_i[FLAG_DONE])) done_flag_q <= 1'b0;
      else if (frame_end_i)                                done_flag_q <= 1'b1;

      if (done_i)         recv_flag_q <= 1'b1;
      else if (data_rd_w) recv_flag_q <= 1'b0;

      if (rd_i) begin
        unique case (addr_i)
          SPIM_ADDR_CFG:  rdata_q <= DATA_W'(cfg_q);
          SPIM_ADDR_BAUD: rdata_q <= DATA_W'(baud_q);
          SPIM_ADDR_DATA: rdata_q <= rx_byte_i;
          default:        rdata_q <= DATA_W'({ie_q, 1'b0, flags_w});
        endcase
      end

      irq_q <= |(flags_w & ie_q);
    end
  end

  assign rdata_o     = rdata_q;
  assign irq_o       = irq_q;
  assign cfg_o       = cfg_q;
  assign baud_o      = baud_q;
  assign hold_full_o = hold_full_q;
  assign hold_data_o = hold_data_q;

  // R7
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (data_wr_w && hold_full_q && !take_i) |=> $stable(hold_data_q));

  // R8
  done_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_flag_q |-> !hold_full_q);

  // R9
  recv_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(recv_flag_q) |-> $past(done_i));

endmodule

// File: rtl/spim_master.sv
`timescale 1ns/1ps
module spim_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              spi_cs_n_o
);

  spim_cfg_t         cfg;
  logic [BAUD_W-1:0] baud;
  logic              hold_full, take, done, frame_end, run, restart, tick;
  logic [DATA_W-1:0] hold_data, rx_byte;

  spim_regs #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .irq_o       (irq_o),
    .cfg_o       (cfg),
    .baud_o      (baud),
    .hold_full_o (hold_full),
    .hold_data_o (hold_data),
    .take_i      (take),
    .done_i      (done),
    .frame_end_i (frame_end),
    .rx_byte_i   (rx_byte)
  );

  spim_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_i     (run),
    .restart_i (restart),
    .baud_i    (baud),
    .tick_o    (tick)
  );

  spim_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cfg_i       (cfg),
    .tick_i      (tick),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .miso_i      (spi_miso_i),
    .take_o      (take),
    .done_o      (done),
    .frame_end_o (frame_end),
    .run_o       (run),
    .restart_o   (restart),
    .rx_byte_o   (rx_byte),
    .sck_o       (spi_sck_o),
    .mosi_o      (spi_mosi_o),
    .cs_n_o      (spi_cs_n_o)
  );

endmodule

// File: tb/test_spim_master.sv
`timescale 1ns/1ps
module test_spim_master;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, spi_sck, spi_mosi, spi_cs_n;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spim_master i_spim_master (
    .clk_i       (clk),
    .rst_i       (rst),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq),
    .spi_sck_o   (spi_sck),
    .spi_mosi_o  (spi_mosi),
    .spi_miso_i  (spi_miso),
    .spi_cs_n_o  (spi_cs_n)
  );

  // slave model settings (written by the main sequence only)
  logic       cur_cpol = 1'b0, cur_cpha = 1'b0, cur_lsb = 1'b0;
  logic [7:0] slv_tx [0:2];
  longint     half_ns = 8;

  // slave model state (written by the slave model only)
  logic [7:0] cap [0:1];
  int         n = 0, edges = 0, cs_falls = 0, gap_err = 0, tail_err = 0;
  longint     t_cs = 0, t_last = 0;
  logic       prev_cs, prev_sck;

  function automatic logic slv_bit(input int k);
    int b, p;
    b = k / 8;
    p = k % 8;
    if (b > 2) return 1'b0;
    return slv_tx[b][cur_lsb ? p : 7 - p];
  endfunction

  always @(spi_sck or spi_cs_n) begin
    if (spi_cs_n !== prev_cs) begin
      if (spi_cs_n === 1'b0) begin
        cs_falls++;
        n = 0;
        edges = 0;
        cap[0] = 8'h00;
        cap[1] = 8'h00;
        t_cs = longint'($time);
        if (!cur_cpha) spi_miso = slv_bit(0);
      end else if (spi_cs_n === 1'b1 && prev_cs === 1'b0) begin
        if (edges > 0 && (longint'($time) - t_last) != half_ns) tail_err++;
      end
      prev_cs = spi_cs_n;
    end
    if (spi_sck !== prev_sck) begin
      if (spi_cs_n === 1'b0) begin
        logic lead;
        edges++;
        if ((longint'($time) - ((edges == 1) ? t_cs : t_last)) != half_ns) gap_err++;
        t_last = longint'($time);
        lead = (spi_sck !== cur_cpol);
        if (lead != cur_cpha) begin
          if (n < 16) cap[n / 8][cur_lsb ? (n % 8) : 7 - (n % 8)] = spi_mosi;
          if (cur_cpha) n++;
        end else begin
          if (!cur_cpha) n++;
          spi_miso = slv_bit(n);
        end
      end
      prev_sck = spi_sck;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_frame();
    int k = 0;
    while (spi_cs_n !== 1'b0 && k < 5000) begin @(negedge clk); k++; end
    while (spi_cs_n !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
    if (k >= 5000) chk("R5 frame did not end", 32'd0, 32'd1);
  endtask

  // {cfg[2:0] = {lsb,cpha,cpol}, baud, mosi byte, miso byte}
  localparam logic [26:0] VEC [6] = '{
    {3'b000, 8'd0, 8'hA5, 8'h3C},
    {3'b010, 8'd1, 8'h96, 8'hC3},
    {3'b101, 8'd2, 8'h01, 8'h80},
    {3'b111, 8'd3, 8'h7E, 8'h5A},
    {3'b100, 8'd4, 8'h80, 8'h01},
    {3'b011, 8'd1, 8'hFF, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int g0, t0, f0;
    slv_tx[0] = 8'h00; slv_tx[1] = 8'h00; slv_tx[2] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 cs_n after reset", spi_cs_n, 1);
    chk("R11 sck after reset", spi_sck, 0);
    chk("R11 mosi after reset", spi_mosi, 0);
    chk("R11 irq after reset", irq, 0);
    rd(3, d); chk("R11 flags after reset", d, 8'h01);
    rd(2, d); chk("R11 data after reset", d, 8'h00);
    rd(0, d); chk("R11 cfg after reset", d, 8'h00);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [26:0] e;
      e = VEC[v];
      cur_cpol = e[24]; cur_cpha = e[25]; cur_lsb = e[26];
      half_ns = (longint'(e[23:16]) + 1) * 8;
      slv_tx[0] = e[7:0]; slv_tx[1] = 8'h00; slv_tx[2] = 8'h00;
      wr(0, {5'd0, e[26:24]});
      wr(1, e[23:16]);
      repeat (2) @(negedge clk);
      chk("R1 idle sck level", spi_sck, e[24]);
      g0 = gap_err; t0 = tail_err;
      wr(2, e[15:8]);
      wait_frame();
      chk("R2 R3 byte seen on MOSI", cap[0], e[15:8]);
      chk("R4 R5 edge spacing", gap_err - g0, 0);
      chk("R5 edges per byte", edges, 16);
      chk("R5 release delay", tail_err - t0, 0);
      chk("R1 sck idle after frame", spi_sck, e[24]);
      rd(3, d); chk("R8 R9 flags after frame", d, 8'h07);
      chk("R10 irq with enables off", irq, 0);
      rd(2, d); chk("R2 R3 byte received from MISO", d, e[7:0]);
      rd(3, d); chk("R9 received flag cleared by read", d, 8'h03);
      wr(3, 8'h02);
      rd(3, d); chk("R8 complete flag cleared by write 1", d, 8'h01);
    end

    // R6 R7 back-to-back with a discarded third write
    cur_cpol = 1'b0; cur_cpha = 1'b0; cur_lsb = 1'b0; half_ns = 16;
    slv_tx[0] = 8'hC1; slv_tx[1] = 8'hD2; slv_tx[2] = 8'h00;
    wr(0, 8'h00); wr(1, 8'd1);
    repeat (2) @(negedge clk);
    g0 = gap_err; t0 = tail_err; f0 = cs_falls;
    wr(2, 8'h11);
    @(negedge clk);
    wr(2, 8'h22);
    rd(3, d); chk("R7 empty flag low while byte waits", d[0], 0);
    wr(2, 8'h33);
    wait_frame();
    chk("R6 first byte", cap[0], 8'h11);
    chk("R7 second byte kept, third discarded", cap[1], 8'h22);
    chk("R6 edges for two bytes", edges, 32);
    chk("R6 no idle between bytes", gap_err - g0, 0);
    chk("R6 chip select held low", cs_falls - f0, 1);
    chk("R5 release after stream", tail_err - t0, 0);
    rd(2, d); chk("R9 last received byte", d, 8'hD2);
    rd(3, d); chk("R8 complete after stream", d, 8'h03);

    // R8 accepted data write clears complete flag
    slv_tx[0] = 8'h00;
    wr(2, 8'h5A);
    rd(3, d); chk("R8 data write clears complete", d, 8'h01);
    wait_frame();
    rd(2, d);

    // R10 interrupt enables
    wr(3, 8'h40);
    @(negedge clk);
    chk("R10 irq low before receive", irq, 0);
    rd(3, d); chk("R10 enable readback", d, 8'h43);
    wr(3, 8'h40);
    wr(2, 8'h0F);
    wait_frame();
    @(negedge clk);
    chk("R10 irq on receive", irq, 1);
    rd(2, d);
    @(negedge clk);
    chk("R10 irq drops after data read", irq, 0);
    wr(3, 8'h10);
    @(negedge clk);
    chk("R10 irq on empty enable", irq, 1);
    wr(3, 8'h00);
    @(negedge clk);
    chk("R10 irq off with no enables", irq, 0);

    // R11 readback and R1 polarity change while idle
    wr(1, 8'h23); rd(1, d); chk("R11 baud readback", d, 8'h23);
    wr(0, 8'h05); rd(0, d); chk("R11 cfg readback", d, 8'h05);
    cur_cpol = 1'b1;
    @(negedge clk);
    chk("R1 sck follows polarity", spi_sck, 1);
    chk("R1 cs_n high while idle", spi_cs_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule